// File: doc/BRIEF.md
# Two-Writer Read-Modify-Write Pipeline with Bypass Cache

This block lets two independent update lanes each perform a read-modify-write on a shared word array in every clock cycle. The storage is replicated into one bank per writer/reader pair. Each word carries a one-bit side marker next to its data. A reader compares the two markers it fetches, one from each writer's bank, and from that comparison it knows which writer last stored the address. A writer derives the marker it stores from the marker of the other writer's copy, and it fetched that marker during its own read phase. No separate marker table exists.

Every request reads its address as it enters. It computes the new word one cycle later and writes it back on the second edge after entry. A plain store also performs this read, so that it can obtain the marker. The banks return the old contents when a word is read and written on the same edge. A recently issued write may therefore not yet be visible to a read. To cover this, a four-entry bypass cache holds the words that are about to be written and the words written on the last edge, for both lanes. When an address matches, the newest matching entry takes priority over the bank contents.

Top module: `rmw_pipe`

## Requirements
- R1: After reset, and in the first two cycles after reset is released, both `res_vld` bits are low.
- R2: An add request (`req_op` bit = 0) stores the old word plus the operand, modulo 2^DATA_W. The stored value appears on `res_data` with `res_vld` high exactly two cycles after the request cycle.
- R3: A store request (`req_op` bit = 1) stores the operand as given. The operand appears on `res_data` two cycles after the request, whatever the old contents were.
- R4: Both lanes may issue requests in the same cycle to distinct addresses, and each lane's result depends only on its own request.
- R5: A value stored by either lane is the old value seen by a later request of the other lane to the same address.
- R6: A request to an address requested one cycle earlier, by either lane, sees the earlier request's result as its old value.
- R7: A request to an address requested two cycles earlier sees that request's result as its old value.
- R8: Requests to an address last requested three or more cycles earlier see the stored value.
- R9: A cycle with a lane's `req_vld` bit low changes no stored word, whatever is on that lane's other request inputs. The matching `res_vld` bit is low two cycles later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_vld | input | 2 | Request valid, bit i for lane i |
| req_addr | input | 2*ADDR_W | Word address, one field per lane |
| req_opnd | input | 2*DATA_W | Operand, one field per lane |
| req_op | input | 2 | Operation per lane: 0 add, 1 store |
| res_vld | output | 2 | Result valid per lane |
| res_data | output | 2*DATA_W | Value written by the lane's request |

## Verification
The bench builds the block with ADDR_W = 3 and DATA_W = 8. With only eight words, short directed sequences hit the same address at distances of one, two and three cycles, from the same lane and from the other lane. This exercises both bypass slots, the bank path and the side markers. The narrow data width lets a single add wrap past 2^DATA_W, which exercises the modulo behaviour.

// File: rtl/rmw_pkg.sv
package rmw_pkg;
    localparam int NLANE  = 2;
    localparam int NCACHE = 2 * NLANE;

    typedef enum logic {
        OP_ADD   = 1'b0,
        OP_WRITE = 1'b1
    } op_e;
endpackage

// File: rtl/rmw_bank.sv
module rmw_bank #(
    parameter int ADDR_W = 4,
    parameter int WORD_W = 17
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [WORD_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [WORD_W-1:0] mem_q [DEPTH];
    logic [WORD_W-1:0] rdata_q;

    // old contents are returned when read and write hit the same edge
    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
        rdata_q <= mem_q[raddr];
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/rmw_fwd.sv
module rmw_fwd #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 16,
    parameter int SELF   = 0
) (
    input  logic [ADDR_W-1:0]                         addr,
    input  logic [rmw_pkg::NCACHE-1:0]                c_vld,
    input  logic [rmw_pkg::NCACHE-1:0][ADDR_W-1:0]    c_addr,
    input  logic [rmw_pkg::NCACHE-1:0][DATA_W-1:0]    c_data,
    input  logic [rmw_pkg::NCACHE-1:0]                c_sel,
    input  logic [DATA_W-1:0]                         ram_data,
    input  logic                                      ram_sel_oth,
    output logic [DATA_W-1:0]                         data,
    output logic                                      sel_oth
);
    import rmw_pkg::*;

    // entry i belongs to lane i % NLANE; lower index is newer
    always_comb begin
        data    = ram_data;
        sel_oth = ram_sel_oth;
        for (int i = NCACHE - 1; i >= 0; i--) begin
            if (c_vld[i] && c_addr[i] == addr) begin
                data = c_data[i];
                if ((i % NLANE) != SELF) begin
                    sel_oth = c_sel[i];
                end
            end
        end
    end
endmodule

// File: rtl/rmw_pipe.sv
module rmw_pipe #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [1:0]                    req_vld,
    input  logic [1:0][ADDR_W-1:0]        req_addr,
    input  logic [1:0][DATA_W-1:0]        req_opnd,
    input  logic [1:0]                    req_op,
    output logic [1:0]                    res_vld,
    output logic [1:0][DATA_W-1:0]        res_data
);
    import rmw_pkg::*;

    localparam int WORD_W = DATA_W + 1;

    typedef struct packed {
        logic              vld;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] opnd;
        op_e               op;
    } rd_t;

    typedef struct packed {
        logic              vld;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic              sel;
    } ent_t;

    typedef struct packed {
        rd_t  [NLANE-1:0] s1;   // read issued, bank data arriving
        ent_t [NLANE-1:0] s2;   // word to be written on next edge
        ent_t [NLANE-1:0] wc;   // word written on the last edge
    } st_t;

    st_t st_d, st_q;

    logic [WORD_W-1:0] rd_word [NLANE][NLANE];   // [writer][reader]

    logic [NCACHE-1:0]             c_vld;
    logic [NCACHE-1:0][ADDR_W-1:0] c_addr;
    logic [NCACHE-1:0][DATA_W-1:0] c_data;
    logic [NCACHE-1:0]             c_sel;

    logic [NLANE-1:0][DATA_W-1:0]  new_data;
    logic [NLANE-1:0]              new_sel;

    always_comb begin
        for (int i = 0; i < NLANE; i++) begin
            c_vld[i]          = st_q.s2[i].vld;
            c_addr[i]         = st_q.s2[i].addr;
            c_data[i]         = st_q.s2[i].data;
            c_sel[i]          = st_q.s2[i].sel;
            c_vld[NLANE+i]    = st_q.wc[i].vld;
            c_addr[NLANE+i]   = st_q.wc[i].addr;
            c_data[NLANE+i]   = st_q.wc[i].data;
            c_sel[NLANE+i]    = st_q.wc[i].sel;
        end
    end

    for (genvar w = 0; w < NLANE; w++) begin : g_wr
        for (genvar r = 0; r < NLANE; r++) begin : g_rd
            rmw_bank #(
                .ADDR_W (ADDR_W),
                .WORD_W (WORD_W)
            ) u_bank (
                .clk   (clk),
                .we    (st_q.s2[w].vld),
                .waddr (st_q.s2[w].addr),
                .wdata ({st_q.s2[w].sel, st_q.s2[w].data}),
                .raddr (req_addr[r]),
                .rdata (rd_word[w][r])
            );
        end
    end

    for (genvar l = 0; l < NLANE; l++) begin : g_lane
        logic              mark0, mark1;
        logic [DATA_W-1:0] ram_old, old_data;
        logic              ram_sel_oth, sel_oth;

        assign mark0       = rd_word[0][l][DATA_W];
        assign mark1       = rd_word[1][l][DATA_W];
        // equal markers: writer 0 stored last; different: writer 1
        assign ram_old     = (mark0 == mark1) ? rd_word[0][l][DATA_W-1:0]
                                              : rd_word[1][l][DATA_W-1:0];
        assign ram_sel_oth = (l == 0) ? mark1 : mark0;

        rmw_fwd #(
            .ADDR_W (ADDR_W),
            .DATA_W (DATA_W),
            .SELF   (l)
        ) u_fwd (
            .addr        (st_q.s1[l].addr),
            .c_vld       (c_vld),
            .c_addr      (c_addr),
            .c_data      (c_data),
            .c_sel       (c_sel),
            .ram_data    (ram_old),
            .ram_sel_oth (ram_sel_oth),
            .data        (old_data),
            .sel_oth     (sel_oth)
        );

        assign new_data[l] = (st_q.s1[l].op == OP_WRITE) ? st_q.s1[l].opnd
                                                         : old_data + st_q.s1[l].opnd;
        assign new_sel[l]  = (l == 0) ? sel_oth : ~sel_oth;
    end

    always_comb begin
        st_d = st_q;
        for (int l = 0; l < NLANE; l++) begin
            st_d.s1[l].vld  = req_vld[l];
            st_d.s1[l].addr = req_addr[l];
            st_d.s1[l].opnd = req_opnd[l];
            st_d.s1[l].op   = op_e'(req_op[l]);
            st_d.s2[l].vld  = st_q.s1[l].vld;
            st_d.s2[l].addr = st_q.s1[l].addr;
            st_d.s2[l].data = new_data[l];
            st_d.s2[l].sel  = new_sel[l];
        end
        st_d.wc = st_q.s2;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar l = 0; l < NLANE; l++) begin : g_out
        assign res_vld[l]  = st_q.s2[l].vld;
        assign res_data[l] = st_q.s2[l].data;
    end

    // ---------------- assertions ----------------
    logic [1:0] age_q;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            age_q <= '0;
        end else if (age_q != 2'd3) begin
            age_q <= age_q + 2'd1;
        end
    end

    assert_idle_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q < 2'd2) |-> (res_vld == 2'b00));

    for (genvar l = 0; l < NLANE; l++) begin : g_chk
        assert_store_passes_operand_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (age_q >= 2'd2 && $past(req_vld[l], 2) && $past(req_op[l], 2) == OP_WRITE)
            |-> (res_vld[l] && res_data[l] == $past(req_opnd[l], 2)));

        assert_no_result_when_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (age_q >= 2'd2 && !$past(req_vld[l], 2)) |-> !res_vld[l]);

        assert_back_to_back_same_lane_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (age_q == 2'd3 && $past(req_vld[l], 2) && $past(req_vld[l], 3)
             && $past(req_addr[l], 2) == $past(req_addr[l], 3)
             && $past(req_op[l], 2) == OP_ADD)
            |-> (res_data[l] == $past(res_data[l]) + $past(req_opnd[l], 2)));
    end

    assert_cross_lane_follow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd3 && $past(req_vld[0], 3) && $past(req_vld[1], 2)
         && $past(req_addr[0], 3) == $past(req_addr[1], 2)
         && $past(req_op[1], 2) == OP_ADD)
        |-> (res_data[1] == $past(res_data[0]) + $past(req_opnd[1], 2)));
endmodule

// File: tb/rmw_pipe_bench.sv
module rmw_pipe_bench;
    localparam int AW = 3;
    localparam int DW = 8;
    localparam int NW = 1 << AW;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic [1:0]           req_vld = '0;
    logic [1:0][AW-1:0]   req_addr = '0;
    logic [1:0][DW-1:0]   req_opnd = '0;
    logic [1:0]           req_op = '0;
    logic [1:0]           res_vld;
    logic [1:0][DW-1:0]   res_data;

    rmw_pipe #(.ADDR_W(AW), .DATA_W(DW)) u_rmw_pipe (
        .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_addr(req_addr),
        .req_opnd(req_opnd), .req_op(req_op), .res_vld(res_vld), .res_data(res_data)
    );

    always #5 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [DW-1:0] ref_mem [NW];
    bit            e1_v [2];
    logic [DW-1:0] e1_d [2];
    string         e1_t [2];
    bit            e2_v [2];
    logic [DW-1:0] e2_d [2];
    string         e2_t [2];

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // one cycle: check result of the request two steps back, then drive
    task automatic step(input bit v0, input int a0, input int d0, input bit op0,
                        input bit v1, input int a1, input int d1, input bit op1,
                        input string tag);
        bit            v [2];
        int            a [2];
        int            d [2];
        bit            op [2];
        logic [DW-1:0] nv;
        v[0] = v0; a[0] = a0; d[0] = d0; op[0] = op0;
        v[1] = v1; a[1] = a1; d[1] = d1; op[1] = op1;
        for (int l = 0; l < 2; l++) begin
            if (e2_v[l]) begin
                check(res_vld[l] === 1'b1, {e2_t[l], " valid"}, int'(res_vld[l]), 1);
                check(res_data[l] === e2_d[l], e2_t[l], int'(res_data[l]), int'(e2_d[l]));
            end else begin
                check(res_vld[l] === 1'b0, {e2_t[l], " idle"}, int'(res_vld[l]), 0);
            end
            e2_v[l] = e1_v[l]; e2_d[l] = e1_d[l]; e2_t[l] = e1_t[l];
        end
        for (int l = 0; l < 2; l++) begin
            e1_v[l] = v[l];
            e1_t[l] = tag;
            e1_d[l] = '0;
            if (v[l]) begin
                nv = op[l] ? DW'(d[l]) : DW'(ref_mem[a[l]] + DW'(d[l]));
                ref_mem[a[l]] = nv;
                e1_d[l] = nv;
            end
            req_vld[l]  = v[l];
            req_addr[l] = AW'(a[l]);
            req_opnd[l] = DW'(d[l]);
            req_op[l]   = op[l];
        end
        @(negedge clk);
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) step(0, i % NW, 8'h5A + i, i[0], 0, (i + 3) % NW, 8'hC3, ~i[0], tag);
    endtask

    task automatic t_reset;
        for (int i = 0; i < 3; i++) begin
            check(res_vld === 2'b00, "R1 reset", int'(res_vld), 0);
            @(negedge clk);
        end
        rst_n = 1'b1;
        for (int i = 0; i < 2; i++) begin
            check(res_vld === 2'b00, "R1 after release", int'(res_vld), 0);
            @(negedge clk);
        end
    endtask

    task automatic t_fill;
        for (int i = 0; i < NW / 2; i++)
            step(1, 2 * i, 8'h10 + 8'(i), 1, 1, 2 * i + 1, 8'hA0 + 8'(i), 1, "R3 R4 store fill");
        idle(3, "R9 gap");
    endtask

    task automatic t_spread;
        for (int i = 0; i < 9; i++)
            step(1, i % 3, 8'h07 * 8'(i + 1), 0, 1, 4 + i % 3, 8'h31 + 8'(i), 0, "R2 R8 spaced add");
        step(1, 0, 8'hF0, 1, 0, 0, 0, 0, "R3 store");
        idle(2, "R9 gap");
        step(1, 0, 8'h25, 0, 0, 0, 0, 0, "R2 wrap add");
        idle(3, "R9 gap");
    endtask

    task automatic t_b2b;
        for (int i = 0; i < 5; i++) step(1, 3, 8'h11 + 8'(i), 0, 0, 0, 0, 0, "R6 same lane b2b");
        for (int i = 0; i < 6; i++) begin
            if (i[0]) step(0, 0, 0, 0, 1, 5, 8'h09 + 8'(i), 0, "R5 R6 cross b2b");
            else      step(1, 5, 8'h40 + 8'(i), 0, 0, 0, 0, 0, "R5 R6 cross b2b");
        end
        step(0, 0, 0, 0, 1, 6, 8'h77, 1, "R3 R5 store lane1");
        step(1, 6, 8'h02, 0, 0, 0, 0, 0, "R5 R6 add after store");
        step(1, 2, 8'h01, 0, 1, 6, 8'h03, 0, "R4 R6 dual lane");
        idle(3, "R9 gap");
    endtask

    task automatic t_gap2;
        for (int i = 0; i < 4; i++) begin
            step(1, 7, 8'h13 + 8'(i), 0, 0, 0, 0, 0, "R7 gap two");
            step(0, 0, 0, 0, 1, 1, 8'h05, 0, "R4 other addr");
        end
        step(1, 4, 8'h21, 0, 0, 0, 0, 0, "R7 cross gap two");
        step(0, 0, 0, 0, 0, 0, 0, 0, "R9 idle");
        step(0, 0, 0, 0, 1, 4, 8'h22, 0, "R5 R7 cross gap two");
        step(0, 0, 0, 0, 0, 0, 0, 0, "R9 idle");
        step(0, 0, 0, 0, 0, 0, 0, 0, "R9 idle");
        step(1, 4, 8'h03, 0, 0, 0, 0, 0, "R5 R8 cross gap three");
        idle(3, "R9 gap");
    endtask

    task automatic t_idle_readback;
        idle(6, "R9 idle noise");
        for (int i = 0; i < NW / 2; i++) begin
            step(1, i, 0, 0, 1, i + NW / 2, 0, 0, "R9 R8 readback");
            idle(2, "R9 gap");
        end
        idle(2, "R9 drain");
    endtask

    initial begin
        for (int l = 0; l < 2; l++) begin
            e1_v[l] = 0; e2_v[l] = 0; e1_d[l] = '0; e2_d[l] = '0;
            e1_t[l] = "R1 start"; e2_t[l] = "R1 start";
        end
        for (int i = 0; i < NW; i++) ref_mem[i] = '0;
        @(negedge clk);
        t_reset();
        t_fill();
        t_spread();
        t_b2b();
        t_gap2();
        t_idle_readback();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule